// File: doc/BRIEF.md
# Four-Channel Mask-Driven Conversion Request Source

This block turns a software-chosen set of analog channels into a stream of conversion requests for a downstream converter arbiter. It serves four channels, numbered 4 to 7. Software writes a channel mask into a control register. A load event then copies that mask into a pending register. The lowest-numbered pending channel is offered to the arbiter. When the arbiter accepts it, that channel's pending bit is dropped and the next one is offered.

A load event can come from three places: a software command, a rising edge on an external trigger pin after two-flop synchronisation, or automatic rescan once the whole pending set has been served. A gate bit stops requests from leaving the block, but the pending state is kept. A clear command empties the pending set. An optional completion interrupt pulses when the last pending channel of a set is accepted. Software reaches the block through a small strobe-based register port. Read data is returned one cycle after the read strobe.

Top module: `par_req_src`

## Requirements
- R1: After reset the mask, the pending set and all mode bits are zero, `req_valid` is low and `irq` is low.
- R2: Address 0 holds the channel mask in bits 3:0, where bit i stands for channel 4+i. Address 2 holds the mode bits: bit0 gate, bit1 trigger enable, bit2 autoscan, bit3 interrupt enable. Unused bits read back as zero. `bus_rdata` is valid on the cycle after a `bus_rd` strobe.
- R3: Writing address 3 with bit0 set copies the mask into the pending set. The pending set reads back at address 1 in bits 3:0.
- R4: Writing address 3 with bit1 set empties the pending set. If bit0 and bit1 are both set, the clear wins.
- R5: `req_valid` is high exactly when the gate bit is set and at least one pending bit is set. `req_chan` gives 4 plus the index of the lowest set pending bit.
- R6: A cycle with `req_ack` and `req_valid` both high clears the offered channel's pending bit at that clock edge. `req_ack` while `req_valid` is low has no effect.
- R7: With trigger enable set, a rising edge on `trig_in` loads the mask into the pending set on the third clock edge after the input rises. A level held high loads only once. With trigger enable clear, the pin has no effect.
- R8: With autoscan set, an accept that empties the pending set is followed one cycle later by a reload of the pending set from the mask.
- R9: With interrupt enable set, `irq` is high for one cycle, the cycle after an accept that empties the pending set. A clear command never raises it.
- R10: A load event in the same cycle as an accept wins. The pending set becomes the full mask.
- R11: Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the read strobe |
| trig_in | input | 1 | Asynchronous external load trigger |
| req_valid | output | 1 | A conversion request is offered |
| req_chan | output | 3 | Channel number of the offered request |
| req_ack | input | 1 | Arbiter accepts the offered request |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the arbiter only acknowledges in cycles where the block itself offers a request. They also assume that at most one bus strobe is active per cycle, so a command and an accept meet only through the ports. The bench drives every input at the falling clock edge and holds it for a full cycle, which keeps the trigger and strobes free of glitches. It raises `req_ack` alone only in the one directed case that checks an unrequested acknowledge is ignored. Under these conditions the offered channel is always a pending channel, every accept removes exactly that channel, and the interrupt only ever follows an emptying accept.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        ADDR_MASK = 2'd0,
        ADDR_PEND = 2'd1,
        ADDR_MODE = 2'd2,
        ADDR_CMD  = 2'd3
    } reg_addr_e;

    // mode register layout, bit3 down to bit0
    typedef struct packed {
        logic irq_en;
        logic scan_en;
        logic trig_en;
        logic gate_en;
    } mode_t;

    // command register layout, bit1 down to bit0
    typedef struct packed {
        logic clear;
        logic load;
    } cmd_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int CMD_W  = $bits(cmd_t);

endpackage

// File: rtl/prs_regs.sv
module prs_regs
    import prs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] mask,
    output mode_t             mode,
    output logic              sw_load,
    output logic              sw_clear,
    output logic [DATA_W-1:0] rdata
);
    reg_addr_e sel;
    cmd_t      cmd;
    logic      unused_wdata;

    assign sel          = reg_addr_e'(addr);
    assign cmd          = cmd_t'(wdata[CMD_W-1:0]);
    assign unused_wdata = ^wdata;

    assign sw_load  = wr && (sel == ADDR_CMD) && cmd.load;
    assign sw_clear = wr && (sel == ADDR_CMD) && cmd.clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            mode <= '0;
        end else if (wr) begin
            case (sel)
                ADDR_MASK: mask <= wdata[NUM_CH-1:0];
                ADDR_MODE: mode <= mode_t'(wdata[MODE_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                ADDR_MASK: rdata <= DATA_W'(mask);
                ADDR_PEND: rdata <= DATA_W'(pend);
                ADDR_MODE: rdata <= DATA_W'(mode);
                default:   rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/prs_trig_sync.sv
module prs_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= trig_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/prs_pend.sv
module prs_pend #(
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 4,
    parameter int CHAN_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] mask,
    input  logic              gate_en,
    input  logic              scan_en,
    input  logic              irq_en,
    input  logic              sw_load,
    input  logic              sw_clear,
    input  logic              trig_load,
    input  logic              req_ack,
    output logic [NUM_CH-1:0] pend,
    output logic              load_evt,
    output logic              req_valid,
    output logic [CHAN_W-1:0] req_chan,
    output logic              irq
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [IDX_W-1:0]  low_idx;
    logic [NUM_CH-1:0] low_bit;
    logic              accept;
    logic              done_q;
    logic              emptying;

    always_comb begin
        low_idx = '0;
        low_bit = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                low_idx = IDX_W'(i);
                low_bit = NUM_CH'(1) << i;
            end
        end
    end

    assign req_valid = gate_en && (pend != '0);
    assign req_chan  = CHAN_W'(CH_BASE) + CHAN_W'(low_idx);
    assign accept    = req_ack && req_valid;
    assign load_evt  = sw_load || trig_load || (done_q && scan_en);
    assign emptying  = accept && !sw_clear && !load_evt && ((pend & ~low_bit) == '0);
    assign irq       = done_q && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= emptying;
            if (sw_clear)      pend <= '0;
            else if (load_evt) pend <= mask;
            else if (accept)   pend <= pend & ~low_bit;
        end
    end
endmodule

// File: rtl/par_req_src.sv
module par_req_src
    import prs_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CH_BASE     = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CHAN_W      = $clog2(CH_BASE + NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_in,
    output logic              req_valid,
    output logic [CHAN_W-1:0] req_chan,
    input  logic              req_ack,
    output logic              irq
);
    logic [NUM_CH-1:0] mask_w;
    logic [NUM_CH-1:0] pend_w;
    mode_t             mode_w;
    logic              sw_load_w;
    logic              sw_clear_w;
    logic              trig_rise_w;
    logic              load_evt_w;

    prs_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pend    (pend_w),
        .mask    (mask_w),
        .mode    (mode_w),
        .sw_load (sw_load_w),
        .sw_clear(sw_clear_w),
        .rdata   (bus_rdata)
    );

    prs_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .trig_in(trig_in),
        .rise   (trig_rise_w)
    );

    prs_pend #(.NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CHAN_W(CHAN_W)) pend_i (
        .clk      (clk),
        .rst      (rst),
        .mask     (mask_w),
        .gate_en  (mode_w.gate_en),
        .scan_en  (mode_w.scan_en),
        .irq_en   (mode_w.irq_en),
        .sw_load  (sw_load_w),
        .sw_clear (sw_clear_w),
        .trig_load(trig_rise_w && mode_w.trig_en),
        .req_ack  (req_ack),
        .pend     (pend_w),
        .load_evt (load_evt_w),
        .req_valid(req_valid),
        .req_chan (req_chan),
        .irq      (irq)
    );
endmodule

// File: rtl/prs_chk.sv
module prs_chk #(
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 4,
    parameter int CHAN_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] pend,
    input logic              req_valid,
    input logic [CHAN_W-1:0] req_chan,
    input logic              req_ack,
    input logic              irq,
    input logic              load_evt,
    input logic              sw_clear
);
    logic [NUM_CH-1:0] chan_bit;

    always_comb begin
        chan_bit = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (CHAN_W'(i + CH_BASE) == req_chan) chan_bit[i] = 1'b1;
        end
    end

    assert_chan_pending_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((pend & chan_bit) != '0));

    assert_chan_lowest_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((pend & (chan_bit - NUM_CH'(1))) == '0));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (req_ack && req_valid && !load_evt && !sw_clear) |=> ((pend & $past(chan_bit)) == '0));

    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (rst)
        sw_clear |=> (pend == '0));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(req_ack && req_valid));
endmodule

bind par_req_src prs_chk #(.NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CHAN_W(CHAN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_w),
    .req_valid(req_valid),
    .req_chan (req_chan),
    .req_ack  (req_ack),
    .irq      (irq),
    .load_evt (load_evt_w),
    .sw_clear (sw_clear_w)
);

// File: tb/par_req_src_tb_top.sv
module par_req_src_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       trig_in = 1'b0;
    logic       req_valid;
    logic [2:0] req_chan;
    logic       req_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    par_req_src dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .req_valid(req_valid), .req_chan(req_chan),
        .req_ack(req_ack), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] mask;
        logic [2:0] first;
        logic [2:0] count;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'b0001, 3'd4, 3'd1},
        '{4'b1000, 3'd7, 3'd1},
        '{4'b1010, 3'd5, 3'd2},
        '{4'b1111, 3'd4, 3'd4},
        '{4'b0110, 3'd5, 3'd2},
        '{4'b0000, 3'd0, 3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack_once();
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [2:0] prev;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        bus_read(2'd1, rd); check(rd == 8'h00, "R1 pend", rd, 0);
        bus_read(2'd0, rd); check(rd == 8'h00, "R1 mask", rd, 0);
        bus_read(2'd2, rd); check(rd == 8'h00, "R1 mode", rd, 0);

        // R2 register access
        bus_write(2'd0, 8'hA5);
        bus_read(2'd0, rd); check(rd == 8'h05, "R2 mask readback", rd, 5);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, rd); check(rd == 8'h0F, "R2 mode readback", rd, 15);
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, rd); check(rd == 8'h01, "R2 mode gate only", rd, 1);

        // table: R3 load, R5 priority, R6 accept
        foreach (VECS[k]) begin
            bus_write(2'd0, {4'b0, VECS[k].mask});
            bus_write(2'd3, 8'h01);
            bus_read(2'd1, rd);
            check(rd == {4'b0, VECS[k].mask}, "R3 load copies mask", rd, VECS[k].mask);
            check(req_valid == (VECS[k].count != 0), "R5 valid", req_valid, VECS[k].count != 0);
            if (VECS[k].count != 0)
                check(req_chan == VECS[k].first, "R5 lowest channel", req_chan, VECS[k].first);
            n = 0;
            prev = 3'd0;
            while (req_valid && n < 8) begin
                if (n > 0) check(req_chan > prev, "R5 ascending order", req_chan, prev + 1);
                prev = req_chan;
                ack_once();
                n++;
            end
            check(n == VECS[k].count, "R6 one accept per channel", n, VECS[k].count);
        end

        // R5 gate off hides requests; R6 ack without valid ignored
        bus_write(2'd0, 8'h03);
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h01);
        check(req_valid == 1'b0, "R5 gate off", req_valid, 0);
        ack_once();
        bus_read(2'd1, rd); check(rd == 8'h03, "R6 ack ignored", rd, 3);

        // R4 clear wins over load
        bus_write(2'd3, 8'h03);
        bus_read(2'd1, rd); check(rd == 8'h00, "R4 clear wins", rd, 0);

        // R11 pend address not writable
        bus_write(2'd1, 8'h0F);
        bus_read(2'd1, rd); check(rd == 8'h00, "R11 pend write ignored", rd, 0);

        // R10 load and accept in same cycle
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, 8'h06);
        bus_write(2'd3, 8'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01; req_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; req_ack = 1'b0;
        bus_read(2'd1, rd); check(rd == 8'h06, "R10 load wins", rd, 6);

        // R4 / R9 clear never raises irq
        bus_write(2'd2, 8'h09);
        bus_write(2'd3, 8'h02);
        check(irq == 1'b0, "R9 no irq on clear", irq, 0);
        @(negedge clk);
        check(irq == 1'b0, "R9 no irq on clear late", irq, 0);

        // R8 / R9 autoscan and completion pulse
        bus_write(2'd0, 8'h05);
        bus_write(2'd2, 8'h0D);
        bus_write(2'd3, 8'h01);
        check(req_chan == 3'd4, "R8 first channel", req_chan, 4);
        ack_once();
        check(req_chan == 3'd6, "R8 second channel", req_chan, 6);
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        check(irq == 1'b1, "R9 irq pulse", irq, 1);
        check(req_valid == 1'b0, "R8 empty before reload", req_valid, 0);
        @(negedge clk);
        check(irq == 1'b0, "R9 irq one cycle", irq, 0);
        check(req_valid == 1'b1 && req_chan == 3'd4, "R8 reloaded", req_chan, 4);

        // R7 trigger path
        bus_write(2'd2, 8'h03);
        bus_write(2'd0, 8'h08);
        bus_write(2'd3, 8'h02);
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(req_valid == 1'b0, "R7 not yet loaded", req_valid, 0);
        @(negedge clk);
        check(req_valid == 1'b1 && req_chan == 3'd7, "R7 trigger load", req_chan, 7);
        bus_write(2'd3, 8'h02);
        repeat (4) @(negedge clk);
        check(req_valid == 1'b0, "R7 held level loads once", req_valid, 0);
        trig_in = 1'b0;
        bus_write(2'd2, 8'h01);
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        check(req_valid == 1'b0, "R7 trigger disabled", req_valid, 0);
        trig_in = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule